// File: doc/BRIEF.md
# PWM input pulse-width capture unit

This block measures an external digital waveform in cycles of its own clock. Each time the waveform finishes a high phase, the length of that phase is latched into a high-duration register. Each time it finishes a low phase, the length is latched into a low-duration register. A status flag sets as each measurement lands. Software clears each flag by writing a one to it. The measured signal is taken from one of several channel pins. By default that is the channel's own pin, and a control field can point it at any other channel's pin.

The selected pin passes through a two-flop synchroniser. An optional glitch filter follows, which accepts a new level only after the level has held for a programmable number of clocks. A run-length counter follows the filter. The counter saturates instead of wrapping, so an over-long phase reads as the maximum value. An interrupt line is raised while any status flag is set, enabled and not masked.

Measurement runs only while the mode field selects capture. The phase that is already in progress when capture starts is discarded: the first accepted level change only arms the measurement.

Top module: `pcap_unit`

## Requirements
- R1: After reset, both duration outputs read 0, both status flags read 0, `irq` is low, the mode is 0 and the input select equals the parameter `SELF_CH`.
- R2: In capture mode, a high phase of N clocks on the selected pin ends with `high_cycles` = N and status bit 1 set, for N from 1 up.
- R3: In capture mode, a low phase of N clocks that lies between two high phases ends with `low_cycles` = N and status bit 0 set.
- R4: Capture mode is mode value 2 in `ctrl[1:0]` of word 0. In any other mode both duration outputs hold their values and no status bit sets. The first level change after capture mode is entered only arms the measurement.
- R5: `ctrl[6:4]` of word 0 selects which bit of `pin_in` is measured. Edges on pins that are not selected have no effect.
- R6: Words 0 to 3 are written with a half-word mask: bit 16+k of the write data enables a change of bit k. With a mask bit at 0, the matching bit keeps its value.
- R7: Word 1 holds the filter enable in bit 0 and the window W in bits 9:4. With the filter enabled and W at 1 or more, a level change is accepted only after the new level has held for W consecutive clocks. Shorter pulses are ignored, and the measured durations of accepted phases are unchanged.
- R8: Word 4 is the status word. Writing 1 to bit k clears status bit k. Writing 0 leaves it set. A bit that is set stays set until it is cleared.
- R9: `irq` is high exactly when some status bit k has interrupt-enable bit k set (word 2) and interrupt-mask bit k clear (word 3).
- R10: A phase longer than 2^CNT_W-1 clocks reports 2^CNT_W-1. The count does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the durations are counted in |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_CH | Asynchronous channel pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 ctrl, 1 filter, 2 irq enable, 3 irq mask, 4 status) |
| reg_wdata | input | 32 | Write data; upper half is the per-bit write mask for words 0 to 3 |
| high_cycles | output | CNT_W | Length of the last completed high phase |
| low_cycles | output | CNT_W | Length of the last completed low phase |
| cap_status | output | 2 | Bit 0 low phase captured, bit 1 high phase captured |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted run-length counter or edge detector shows up as a wrong value on `high_cycles` or `low_cycles`, roughly four clocks after the selected pin changes level. The path from pin to output is two synchroniser flops, the filter flop, and the flop that latches the count. Widths of 1 to 6 clocks are swept against each other, so an off-by-one error at either end of a phase cannot hide. A filter that is miscounting either lets a pulse one clock shorter than the window through, or swallows a pulse of exactly the window length. Both show as a changed or unchanged duration on the next capture. Errors in status or mask handling appear on `irq` in the same cycle as the register write.

// File: rtl/pcap_pkg.sv
// Shared definitions for the pulse-width capture unit.
// Holds the register word indices, the mode encoding and the write-mask merge.
package pcap_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_FILT = 3'd1;
    localparam logic [REG_AW-1:0] A_IEN  = 3'd2;
    localparam logic [REG_AW-1:0] A_IMSK = 3'd3;
    localparam logic [REG_AW-1:0] A_STAT = 3'd4;

    localparam int SEL_LSB = 4;   // input select field position in word 0
    localparam int WIN_LSB = 4;   // filter window field position in word 1
    localparam int NSTAT   = 2;   // bit 0 low done, bit 1 high done

    typedef enum logic [1:0] {
        PM_ONESHOT = 2'd0,
        PM_CONT    = 2'd1,
        PM_CAPTURE = 2'd2,
        PM_RSVD    = 2'd3
    } pcap_mode_e;

    // Lower half of a write takes effect only where the upper half has a 1.
    function automatic logic [15:0] merge16(input logic [15:0] old,
                                            input logic [31:0] wdata);
        return (old & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);
    endfunction

endpackage

// File: rtl/pcap_insync.sv
// Input selector and synchroniser.
// Picks one channel pin and passes it through STAGES flops.
// Assumes NUM_CH is a power of two, so every select value names a pin,
// and STAGES is at least 2.
module pcap_insync #(
    parameter int NUM_CH = 8,
    parameter int STAGES = 2,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pins_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              lvl_o
);

    logic [STAGES-1:0] sh_q;

    // Shift the selected pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], pins_i[sel_i]};
    end

    assign lvl_o = sh_q[STAGES-1];

endmodule

// File: rtl/pcap_filter.sv
// Glitch filter.
// When enabled, the output follows the input only after the input has
// differed from the output for win_i consecutive clocks. A window of 0 acts
// like 1. When disabled, the output is the input delayed by one flop, so
// both settings add the same latency at a window of 1.
module pcap_filter #(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             raw_i,
    output logic             lvl_o
);

    logic [WIN_W-1:0] cnt_q;
    logic             lvl_q;
    logic [WIN_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

    // Count consecutive disagreeing clocks and accept the level at the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (!en_i) begin
            lvl_q <= raw_i;
            cnt_q <= '0;
        end else if (raw_i == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_nxt >= {1'b0, win_i}) begin
            lvl_q <= raw_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt[WIN_W-1:0];
        end
    end

    assign lvl_o = lvl_q;

    // R7: with a window of 2 or more, a level change follows a full window.
    p_filter_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && $past(win_i) >= 2 && lvl_q != $past(lvl_q))
        |-> ({1'b0, $past(cnt_q)} + 1'b1 == {1'b0, $past(win_i)}));

endmodule

// File: rtl/pcap_meter.sv
// Phase run-length meter.
// Counts clocks since the last change of the filtered level, saturating at
// all ones. Latches the count into the high or low result at each change.
// The first change after cap_en rises only arms the meter.
module pcap_meter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             lvl_i,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o,
    output logic             hi_done,
    output logic             lo_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             lvl_d;
    logic             armed_q;
    logic [CNT_W-1:0] run_q;
    logic             lvl_chg;

    assign lvl_chg = lvl_i != lvl_d;
    assign hi_done = cap_en && armed_q && lvl_chg &&  lvl_d;
    assign lo_done = cap_en && armed_q && lvl_chg && !lvl_d;

    // Track the level, arm on the first change and run the saturating counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d   <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= '0;
        end else begin
            lvl_d <= lvl_i;
            if (!cap_en) begin
                armed_q <= 1'b0;
                run_q   <= '0;
            end else if (lvl_chg) begin
                armed_q <= 1'b1;
                run_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
            end else if (run_q != CNT_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Latch the finished phase length into its result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_o <= '0;
            lo_o <= '0;
        end else begin
            if (hi_done) hi_o <= run_q;
            if (lo_done) lo_o <= run_q;
        end
    end

    // R10: once at the maximum, the counter stays there until the phase ends.
    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cap_en && !lvl_chg && run_q == CNT_MAX) |-> run_q == CNT_MAX);

    // R2: a single level change completes at most one phase.
    p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_done, lo_done}));

endmodule

// File: rtl/pcap_unit.sv
// Pulse-width capture unit, top level.
// Holds the control, filter, interrupt enable, mask and status registers.
// Wires the selector, filter and meter together and drives the interrupt.
// Assumes single-word writes, with NUM_CH a power of two of at most 4096 and
// WIN_W of at most 12.
module pcap_unit
    import pcap_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int CNT_W   = 32,
    parameter int WIN_W   = 6,
    parameter int SELF_CH = 0,
    localparam int SEL_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [CNT_W-1:0]  high_cycles,
    output logic [CNT_W-1:0]  low_cycles,
    output logic [NSTAT-1:0]  cap_status,
    output logic              irq
);

    pcap_mode_e       mode_q;
    logic [SEL_W-1:0] sel_q;
    logic             fen_q;
    logic [WIN_W-1:0] fwin_q;
    logic [NSTAT-1:0] ien_q;
    logic [NSTAT-1:0] imsk_q;
    logic [NSTAT-1:0] stat_q;

    logic [15:0] ctrl_cur, filt_cur, ctrl_new, filt_new, ien_new, imsk_new;
    logic [NSTAT-1:0] stat_clr;
    logic             cap_en;
    logic             sync_lvl, filt_lvl;
    logic             hi_done, lo_done;
    logic             unused_bits;

    // Build the current register images and merge them with the write data.
    always_comb begin
        ctrl_cur = '0;
        ctrl_cur[1:0] = mode_q;
        ctrl_cur[SEL_LSB +: SEL_W] = sel_q;
        filt_cur = '0;
        filt_cur[0] = fen_q;
        filt_cur[WIN_LSB +: WIN_W] = fwin_q;
        ctrl_new = merge16(ctrl_cur, reg_wdata);
        filt_new = merge16(filt_cur, reg_wdata);
        ien_new  = merge16({{(16-NSTAT){1'b0}}, ien_q}, reg_wdata);
        imsk_new = merge16({{(16-NSTAT){1'b0}}, imsk_q}, reg_wdata);
        stat_clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[NSTAT-1:0] : '0;
    end

    assign unused_bits = ^{ctrl_new, filt_new, ien_new, imsk_new};

    // Masked writes into the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_ONESHOT;
            sel_q  <= SEL_W'(SELF_CH);
            fen_q  <= 1'b0;
            fwin_q <= '0;
            ien_q  <= '0;
            imsk_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    mode_q <= pcap_mode_e'(ctrl_new[1:0]);
                    sel_q  <= ctrl_new[SEL_LSB +: SEL_W];
                end
                A_FILT: begin
                    fen_q  <= filt_new[0];
                    fwin_q <= filt_new[WIN_LSB +: WIN_W];
                end
                A_IEN:   ien_q  <= ien_new[NSTAT-1:0];
                A_IMSK:  imsk_q <= imsk_new[NSTAT-1:0];
                default: ;
            endcase
        end
    end

    // Sticky status flags: a completed capture sets, a written one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | {hi_done, lo_done};
    end

    assign cap_en = (mode_q == PM_CAPTURE);

    pcap_insync #(.NUM_CH(NUM_CH), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pin_in),
        .sel_i  (sel_q),
        .lvl_o  (sync_lvl)
    );

    pcap_filter #(.WIN_W(WIN_W)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (fen_q),
        .win_i (fwin_q),
        .raw_i (sync_lvl),
        .lvl_o (filt_lvl)
    );

    pcap_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .lvl_i   (filt_lvl),
        .hi_o    (high_cycles),
        .lo_o    (low_cycles),
        .hi_done (hi_done),
        .lo_done (lo_done)
    );

    assign cap_status = stat_q;
    assign irq        = |(stat_q & ien_q & ~imsk_q);

    // R8: a high-capture flag survives every cycle that does not clear it.
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !(reg_we && reg_addr == A_STAT && reg_wdata[1]))
        |=> stat_q[1]);

    // R4: outside capture mode the results do not move.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> ($stable(high_cycles) && $stable(low_cycles)));

    // R9: a fully masked set of flags never raises the interrupt.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~imsk_q) == '0) |-> !irq);

endmodule

// File: tb/pcap_unit_tb.sv
`timescale 1ns/1ps
module pcap_unit_tb;

    localparam int NCH  = 8;
    localparam int CW   = 10;
    localparam int SATV = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pins = '0;
    logic           reg_we = 1'b0;
    logic [2:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [CW-1:0]  high_cycles, low_cycles;
    logic [1:0]     cap_status;
    logic           irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pcap_unit #(.NUM_CH(NCH), .CNT_W(CW), .WIN_W(6), .SELF_CH(0)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pins),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .high_cycles (high_cycles),
        .low_cycles  (low_cycles),
        .cap_status  (cap_status),
        .irq         (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int ch, input int hn, input int ln);
        pins[ch] = 1'b1;
        repeat (hn) @(negedge clk);
        pins[ch] = 1'b0;
        repeat (ln) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 high", int'(high_cycles), 0);
        chk("R1 low", int'(low_cycles), 0);
        chk("R1 status", int'(cap_status), 0);
        chk("R1 irq", int'(irq), 0);

        // R4 capture mode = 2 in bits 1:0, written with mask bits 17:16 (R6)
        wr(3'd0, 32'h0003_0002);
        repeat (10) @(negedge clk);

        // R2/R3 sweep of high and low widths
        for (int h = 1; h <= 6; h++) begin
            for (int l = 1; l <= 6; l++) begin
                wr(3'd4, 32'h0000_0003);
                pins[0] = 1'b1; repeat (h) @(negedge clk);
                pins[0] = 1'b0; repeat (l) @(negedge clk);
                pins[0] = 1'b1; repeat (10) @(negedge clk);
                chk("R2 high width", int'(high_cycles), h);
                chk("R3 low width", int'(low_cycles), l);
                chk("R2 R3 status", int'(cap_status), 3);
                repeat (10) @(negedge clk);
                pins[0] = 1'b0; repeat (10) @(negedge clk);
                chk("R2 long high", int'(high_cycles), 20);
                repeat (10) @(negedge clk);
            end
        end

        // R7 filter enable bit 0, window 4 in bits 9:4
        wr(3'd1, 32'h03F1_0041);
        wr(3'd4, 32'h0000_0003);
        pulse(0, 3, 20);
        chk("R7 short pulse status", int'(cap_status[1]), 0);
        chk("R7 short pulse high", int'(high_cycles), 20);
        pulse(0, 4, 20);
        chk("R7 window pulse", int'(high_cycles), 4);
        pulse(0, 7, 20);
        chk("R7 filtered width", int'(high_cycles), 7);
        pins[0] = 1'b1; repeat (10) @(negedge clk);
        pins[0] = 1'b0; repeat (2) @(negedge clk);
        pins[0] = 1'b1; repeat (10) @(negedge clk);
        pins[0] = 1'b0; repeat (20) @(negedge clk);
        chk("R7 glitch absorbed", int'(high_cycles), 22);
        wr(3'd1, 32'h0001_0000);

        // R9 interrupt enable on bit 1
        wr(3'd2, 32'h0003_0002);
        wr(3'd4, 32'h0000_0003);
        chk("R9 irq after clear", int'(irq), 0);
        pulse(0, 5, 20);
        chk("R9 irq raised", int'(irq), 1);
        wr(3'd3, 32'h0003_0002);
        chk("R9 irq masked", int'(irq), 0);
        chk("R9 masked still sets", int'(cap_status[1]), 1);
        wr(3'd3, 32'h0003_0000);
        chk("R9 irq unmasked", int'(irq), 1);
        wr(3'd4, 32'h0000_0000);
        chk("R8 zero write keeps", int'(cap_status[1]), 1);
        wr(3'd4, 32'h0000_0002);
        chk("R8 cleared", int'(cap_status[1]), 0);
        chk("R9 irq after clear", int'(irq), 0);

        // R6 write with no mask bits leaves the mode at capture
        wr(3'd0, 32'h0000_0000);
        pulse(0, 9, 20);
        chk("R6 unmasked write ignored", int'(high_cycles), 9);

        // R4 mode 0 halts capture
        wr(3'd0, 32'h0003_0000);
        wr(3'd4, 32'h0000_0003);
        pulse(0, 11, 20);
        chk("R4 idle high held", int'(high_cycles), 9);
        chk("R4 idle no status", int'(cap_status), 0);
        wr(3'd0, 32'h0003_0002);

        // R5 select channel 3 via bits 6:4
        wr(3'd0, 32'h0070_0030);
        pulse(0, 13, 20);
        chk("R5 other pin ignored", int'(high_cycles), 9);
        chk("R5 R4 first edge arms", int'(cap_status), 0);
        pulse(3, 13, 20);
        chk("R5 selected pin", int'(high_cycles), 13);
        wr(3'd0, 32'h0070_0000);

        // R10 saturation
        pulse(0, SATV + 77, 20);
        chk("R10 saturated", int'(high_cycles), SATV);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule